// File: doc/BRIEF.md
# Length-Decoded Serial Register Loader

This block is a serial configuration port that fills one of three registers without any address or steering bits. A host pulls the active-low enable low, shifts bits MSB first on rising edges of the serial clock, and releases the enable. The number of rising edges counted during that window picks the destination: 8 bits go to the configuration register, 16 bits go to the R register and 24 bits go to the A register. Any other count up to 31 is discarded. Counts of 32 or more are treated as a cascade pass-through: the last 24 bits shifted are kept for the A register. The serial clock, data and enable are brought into a faster system clock with two-flop synchronizers, and all edges are detected in that domain.

The R register is split. Its top three control bits take effect as soon as a 16-bit frame is committed. Its lower 13-bit divider field is double-buffered: a 16-bit frame writes only a staging copy, and the active copy takes that value either when the A register is committed or when the enable is pulsed low and back high with no clock edge in between. Two bits of the A register choose what the general-purpose output carries. It can show a reference divider pulse, a main divider pulse, the serial data-out stream for daisy-chaining, or a static level.

Top module: `lenSerialLoader`

## Requirements
- R1: After reset every register output is zero and gpOut is 0. Bits are taken MSB first on rising serClk edges, and only while serEnN is low.
- R2: A frame of exactly 8 bits writes them to cfgReg when serEnN rises and leaves every other register unchanged.
- R3: A frame of exactly 16 bits writes frame bits 15:13 to rCtrl and bits 12:0 to rStage. rActive is left unchanged.
- R4: A frame of exactly 24 bits writes aReg and, in the same commit, copies rStage into rActive.
- R5: When serEnN goes low and back high with no rising serClk edge in between, rStage is copied into rActive and no other register changes.
- R6: Frames of 1 to 7, 9 to 15, 17 to 23 or 25 to 31 bits change no register.
- R7: A frame of 32 or more bits is committed like a 24-bit frame, using the last 24 bits shifted. The bit count saturates, so arbitrarily long frames behave the same way.
- R8: No register changes while a frame is still open. Updates happen only when serEnN rises.
- R9: aReg[23:22] selects gpOut: 2'b11 gives refPulse, 2'b10 gives mainPulse, 2'b01 gives the serial data-out bit, and 2'b00 gives the static level aReg[21].
- R10: The data-out bit changes on falling serClk edges while serEnN is low. It takes the bit held in the 24th shift stage, so it is 0 until 24 bits have been shifted, and after falling edge k (k>=24) it equals the bit shifted at rising edge k-23. It returns to 0 while serEnN is high.
- R11: While serEnN is high the shift logic stays cleared. Clock edges in that state are ignored and do not count toward the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rstN | input | 1 | Active-low asynchronous reset |
| serClk | input | 1 | Serial clock; data sampled on its rising edge |
| serData | input | 1 | Serial data in, MSB first |
| serEnN | input | 1 | Active-low frame enable; rising edge commits |
| refPulse | input | 1 | Reference divider pulse routed to gpOut in mode 2'b11 |
| mainPulse | input | 1 | Main divider pulse routed to gpOut in mode 2'b10 |
| cfgReg | output | 8 | Configuration register |
| rCtrl | output | 3 | R register control bits, immediate |
| rStage | output | 13 | R divider field, first buffer |
| rActive | output | 13 | R divider field, second (active) buffer |
| aReg | output | 24 | A register |
| gpOut | output | 1 | General-purpose output selected by aReg[23:22] |

## Verification
The hardest states to reach are the data-out stream in the middle of a frame and the promotion without clocks. Data-out only shows on gpOut once the A register holds mode 2'b01, so the bench first commits such an A value. It then shifts a 32-bit cascade frame whose last 24 bits keep that mode, and samples gpOut after chosen falling edges, both before and after the 24-bit delay. The promotion without clocks is checked after a 16-bit frame has left rStage and rActive different, so the copy shows up as a visible change at the ports.

// File: rtl/lenload_pkg.sv
package lenload_pkg;

  // Strobes from the frame controller to the register datapath
  typedef struct packed {
    logic bitIn;    // synchronized serial data bit
    logic shift;    // rising serial clock inside a frame
    logic fall;     // falling serial clock inside a frame
    logic hold;     // enable inactive: keep shift logic cleared
    logic ldCfg;    // commit 8-bit frame
    logic ldR;      // commit 16-bit frame
    logic ldA;      // commit 24-bit or cascade frame
    logic promote;  // copy staged R divider field to active copy
  } strobe_t;

  typedef enum logic [1:0] {
    SEL_PORT = 2'b00,
    SEL_DOUT = 2'b01,
    SEL_MAIN = 2'b10,
    SEL_REF  = 2'b11
  } outSel_e;

endpackage

// File: rtl/lenload_ctrl.sv
module lenload_ctrl
  import lenload_pkg::*;
#(
  parameter int CFG_W       = 8,
  parameter int R_W         = 16,
  parameter int A_W         = 24,
  parameter int CASCADE_MIN = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    serClk,
  input  logic    serData,
  input  logic    serEnN,
  output strobe_t st
);

  localparam int SAT   = CASCADE_MIN + 1;
  localparam int CNT_W = $clog2(SAT + 1);
  localparam logic [CNT_W-1:0] LEN_CFG  = CNT_W'(CFG_W);
  localparam logic [CNT_W-1:0] LEN_R    = CNT_W'(R_W);
  localparam logic [CNT_W-1:0] LEN_A    = CNT_W'(A_W);
  localparam logic [CNT_W-1:0] LEN_CASC = CNT_W'(CASCADE_MIN);
  localparam logic [CNT_W-1:0] LEN_SAT  = CNT_W'(SAT);

  // Synchronizer chains; the extra top stage holds the previous synced value
  logic [SYNC_STAGES:0]   clkPipe;
  logic [SYNC_STAGES:0]   enPipe;
  logic [SYNC_STAGES-1:0] dataPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPipe  <= '0;
      enPipe   <= '1;
      dataPipe <= '0;
    end else begin
      clkPipe  <= {clkPipe[SYNC_STAGES-1:0], serClk};
      enPipe   <= {enPipe[SYNC_STAGES-1:0], serEnN};
      dataPipe <= {dataPipe[SYNC_STAGES-2:0], serData};
    end
  end

  logic clkRise, clkFall, enHigh, enRise;
  assign clkRise = clkPipe[SYNC_STAGES-1] & ~clkPipe[SYNC_STAGES];
  assign clkFall = ~clkPipe[SYNC_STAGES-1] & clkPipe[SYNC_STAGES];
  assign enHigh  = enPipe[SYNC_STAGES-1];
  assign enRise  = enHigh & ~enPipe[SYNC_STAGES];

  // Frame bit counter, saturating just past the cascade length
  logic [CNT_W-1:0] bitCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                bitCount <= '0;
    else if (enHigh)                          bitCount <= '0;
    else if (clkRise && bitCount != LEN_SAT)  bitCount <= bitCount + 1'b1;
  end

  logic isCascade;
  assign isCascade = (bitCount >= LEN_CASC);

  always_comb begin
    st         = '0;
    st.bitIn   = dataPipe[SYNC_STAGES-1];
    st.shift   = clkRise & ~enHigh;
    st.fall    = clkFall & ~enHigh;
    st.hold    = enHigh;
    st.ldCfg   = enRise & (bitCount == LEN_CFG);
    st.ldR     = enRise & (bitCount == LEN_R);
    st.ldA     = enRise & ((bitCount == LEN_A) | isCascade);
    st.promote = enRise & ((bitCount == '0) | (bitCount == LEN_A) | isCascade);
  end

  // R2/R3/R4: a commit never targets more than one register
  a_r2_single_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.ldCfg, st.ldR, st.ldA}));

  // R7: counter never runs past its saturation value
  a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    bitCount <= LEN_SAT);

  // R8: no commit strobe while a shift is in progress
  a_r8_no_commit_mid_shift: assert property (@(posedge clk) disable iff (!rstN)
    st.shift |-> !(st.ldCfg || st.ldR || st.ldA || st.promote));

endmodule

// File: rtl/lenload_datapath.sv
module lenload_datapath
  import lenload_pkg::*;
#(
  parameter int CFG_W  = 8,
  parameter int R_W    = 16,
  parameter int R_LO_W = 13,
  parameter int A_W    = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             st,
  input  logic                refPulse,
  input  logic                mainPulse,
  output logic [CFG_W-1:0]    cfgReg,
  output logic [R_W-R_LO_W-1:0] rCtrl,
  output logic [R_LO_W-1:0]   rStage,
  output logic [R_LO_W-1:0]   rActive,
  output logic [A_W-1:0]      aReg,
  output logic                gpOut
);

  localparam int R_HI_W = R_W - R_LO_W;

  logic [A_W-1:0] shReg;
  logic           dataOut;

  // Shift register and daisy-chain output
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      dataOut <= 1'b0;
    end else if (st.hold) begin
      shReg   <= '0;
      dataOut <= 1'b0;
    end else begin
      if (st.shift) shReg   <= {shReg[A_W-2:0], st.bitIn};
      if (st.fall)  dataOut <= shReg[A_W-1];
    end
  end

  // Committed registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg  <= '0;
      rCtrl   <= '0;
      rStage  <= '0;
      rActive <= '0;
      aReg    <= '0;
    end else begin
      if (st.ldCfg) cfgReg <= shReg[CFG_W-1:0];
      if (st.ldR) begin
        rCtrl  <= shReg[R_W-1:R_LO_W];
        rStage <= shReg[R_LO_W-1:0];
      end
      if (st.ldA)     aReg    <= shReg;
      if (st.promote) rActive <= rStage;
    end
  end

  // General-purpose output select
  outSel_e outSel;
  assign outSel = outSel_e'(aReg[A_W-1:A_W-2]);

  always_comb begin
    case (outSel)
      SEL_REF:  gpOut = refPulse;
      SEL_MAIN: gpOut = mainPulse;
      SEL_DOUT: gpOut = dataOut;
      default:  gpOut = aReg[A_W-3];
    endcase
  end

  // R8: registers hold while bits are being shifted
  a_r8_stable_while_shifting: assert property (@(posedge clk) disable iff (!rstN)
    st.shift |=> ($stable(cfgReg) && $stable(aReg) && $stable(rStage)
                  && $stable(rActive) && $stable(rCtrl)));

  // R6: with no commit strobe nothing is written
  a_r6_no_strobe_no_change: assert property (@(posedge clk) disable iff (!rstN)
    !(st.ldCfg || st.ldR || st.ldA || st.promote)
      |=> ($stable(cfgReg) && $stable(aReg) && $stable(rStage) && $stable(rActive)));

  // R4: an A commit promotes the staged divider field
  a_r4_promote_on_a: assert property (@(posedge clk) disable iff (!rstN)
    st.ldA |=> (rActive == $past(rStage)));

  // R11: enable inactive keeps the shift logic cleared
  a_r11_hold_clears: assert property (@(posedge clk) disable iff (!rstN)
    st.hold |=> (shReg == '0 && dataOut == 1'b0));

endmodule

// File: rtl/lenSerialLoader.sv
module lenSerialLoader
  import lenload_pkg::*;
#(
  parameter int CFG_W       = 8,
  parameter int R_W         = 16,
  parameter int R_LO_W      = 13,
  parameter int A_W         = 24,
  parameter int CASCADE_MIN = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  serClk,
  input  logic                  serData,
  input  logic                  serEnN,
  input  logic                  refPulse,
  input  logic                  mainPulse,
  output logic [CFG_W-1:0]      cfgReg,
  output logic [R_W-R_LO_W-1:0] rCtrl,
  output logic [R_LO_W-1:0]     rStage,
  output logic [R_LO_W-1:0]     rActive,
  output logic [A_W-1:0]        aReg,
  output logic                  gpOut
);

  strobe_t st;

  lenload_ctrl #(
    .CFG_W(CFG_W), .R_W(R_W), .A_W(A_W),
    .CASCADE_MIN(CASCADE_MIN), .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serEnN(serEnN), .st(st)
  );

  lenload_datapath #(
    .CFG_W(CFG_W), .R_W(R_W), .R_LO_W(R_LO_W), .A_W(A_W)
  ) uData (
    .clk(clk), .rstN(rstN), .st(st), .refPulse(refPulse),
    .mainPulse(mainPulse), .cfgReg(cfgReg), .rCtrl(rCtrl),
    .rStage(rStage), .rActive(rActive), .aReg(aReg), .gpOut(gpOut)
  );

endmodule

// File: tb/sim_lenSerialLoader.sv
module sim_lenSerialLoader;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, serEnN = 1'b1;
  logic refPulse = 1'b0, mainPulse = 1'b0;
  logic [7:0]  cfgReg;
  logic [2:0]  rCtrl;
  logic [12:0] rStage, rActive;
  logic [23:0] aReg;
  logic        gpOut;

  int errors = 0;
  int checks = 0;
  localparam int HP = 8;

  always #4 clk = ~clk;

  lenSerialLoader u0 (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serEnN(serEnN), .refPulse(refPulse), .mainPulse(mainPulse),
    .cfgReg(cfgReg), .rCtrl(rCtrl), .rStage(rStage), .rActive(rActive),
    .aReg(aReg), .gpOut(gpOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic beginFrame();
    @(negedge clk); serEnN = 1'b0; waitCyc(HP);
  endtask

  task automatic shiftBits(input logic [63:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      serData = v[i]; waitCyc(HP);
      serClk = 1'b1;  waitCyc(HP);
      serClk = 1'b0;
    end
    waitCyc(HP);
  endtask

  task automatic endFrame();
    serEnN = 1'b1; waitCyc(HP);
  endtask

  task automatic sendFrame(input logic [63:0] v, input int n);
    beginFrame(); shiftBits(v, n); endFrame();
  endtask

  task automatic tReset();
    chk("R1 cfgReg", 32'(cfgReg), 0);
    chk("R1 rCtrl", 32'(rCtrl), 0);
    chk("R1 rStage", 32'(rStage), 0);
    chk("R1 rActive", 32'(rActive), 0);
    chk("R1 aReg", 32'(aReg), 0);
    chk("R1 gpOut", 32'(gpOut), 0);
  endtask

  task automatic tCfg();
    sendFrame(64'hA5, 8);
    chk("R2 cfgReg", 32'(cfgReg), 32'hA5);
    chk("R2 aReg untouched", 32'(aReg), 0);
    chk("R2 rStage untouched", 32'(rStage), 0);
  endtask

  task automatic tOpenFrame();
    beginFrame(); shiftBits(64'h5A, 8);
    chk("R8 cfgReg held mid-frame", 32'(cfgReg), 32'hA5);
    endFrame();
    chk("R8 cfgReg after commit", 32'(cfgReg), 32'h5A);
  endtask

  task automatic tR16();
    sendFrame(64'hB123, 16);
    chk("R3 rCtrl", 32'(rCtrl), 32'h5);
    chk("R3 rStage", 32'(rStage), 32'h1123);
    chk("R3 rActive unchanged", 32'(rActive), 0);
  endtask

  task automatic tA24();
    sendFrame(64'h2ABCDE, 24);
    chk("R4 aReg", 32'(aReg), 32'h2ABCDE);
    chk("R4 rActive promoted", 32'(rActive), 32'h1123);
    chk("R9 port level", 32'(gpOut), 1);
  endtask

  task automatic tPulse();
    sendFrame(64'h0456, 16);
    chk("R5 rActive before pulse", 32'(rActive), 32'h1123);
    beginFrame(); endFrame();
    chk("R5 rActive after pulse", 32'(rActive), 32'h0456);
    chk("R5 aReg unchanged", 32'(aReg), 32'h2ABCDE);
  endtask

  task automatic tIllegal();
    sendFrame(64'hFFF, 12);
    sendFrame(64'h1FFFFFF, 25);
    sendFrame(64'h1F, 5);
    sendFrame(64'h7FFFFFFF, 31);
    chk("R6 cfgReg", 32'(cfgReg), 32'h5A);
    chk("R6 rCtrl", 32'(rCtrl), 0);
    chk("R6 rStage", 32'(rStage), 32'h0456);
    chk("R6 rActive", 32'(rActive), 32'h0456);
    chk("R6 aReg", 32'(aReg), 32'h2ABCDE);
  endtask

  task automatic tHold();
    serData = 1'b1;
    for (int i = 0; i < 5; i++) begin
      serClk = 1'b1; waitCyc(HP); serClk = 1'b0; waitCyc(HP);
    end
    sendFrame(64'h3C, 8);
    chk("R11 clocks ignored while idle", 32'(cfgReg), 32'h3C);
  endtask

  task automatic tChain();
    logic [31:0] w;
    w = 32'hC35A1234;
    sendFrame(64'h400000, 24);
    chk("R9 data-out idle", 32'(gpOut), 0);
    beginFrame();
    for (int i = 1; i <= 32; i++) begin
      serData = w[32 - i]; waitCyc(HP);
      serClk = 1'b1; waitCyc(HP);
      serClk = 1'b0; waitCyc(6);
      if (i == 10) chk("R10 data-out before 24 bits", 32'(gpOut), 0);
      if (i >= 24 && i <= 27)
        chk("R10 data-out stream", 32'(gpOut), 32'(w[31 - (i - 24)]));
      waitCyc(HP - 6);
    end
    chk("R8 aReg held mid-frame", 32'(aReg), 32'h400000);
    endFrame();
    chk("R7 cascade keeps last 24", 32'(aReg), 32'h5A1234);
    chk("R10 data-out cleared", 32'(gpOut), 0);
  endtask

  task automatic tLongAndModes();
    sendFrame(64'hFF_FFFF_C00F0F, 40);
    chk("R7 saturated long frame", 32'(aReg), 32'hC00F0F);
    refPulse = 1'b1; mainPulse = 1'b0; waitCyc(2);
    chk("R9 ref pulse high", 32'(gpOut), 1);
    refPulse = 1'b0; mainPulse = 1'b1; waitCyc(2);
    chk("R9 ref pulse low", 32'(gpOut), 0);
    sendFrame(64'h800000, 24);
    chk("R9 main pulse", 32'(gpOut), 1);
    mainPulse = 1'b0; waitCyc(2);
    chk("R9 main pulse low", 32'(gpOut), 0);
  endtask

  initial begin
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(5);
    tReset();
    tCfg();
    tOpenFrame();
    tR16();
    tA24();
    tPulse();
    tIllegal();
    tHold();
    tChain();
    tLongAndModes();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule